// File: doc/BRIEF.md
# Exclusive Pair Load Unit

This block executes a load-exclusive-pair instruction in one in-order pipeline stage. When an instruction word is offered, the unit decodes it and reads the base register through a combinational register-read port, using the stack pointer when the base field is 31. It then issues a single memory read for two consecutive elements of 32 or 64 bits. In the cycle that read request appears, it also arms a local exclusive monitor with the address and the byte count of the pair.

When the memory response arrives, the unit splits the data into two elements. It writes them to the two destination registers, and the order of the two elements depends on the endianness input. Register 31 is the zero register, so writes to it are dropped. A misaligned stack pointer raises an alignment fault, and an encoding that does not match raises an undefined-instruction fault. Two equal destination fields are handled by a policy chosen on an input. The acquire and tag-check qualifiers are not acted on here: they travel with the request as sideband bits. A store-exclusive check port compares a store against the armed monitor and always clears it.

Top module: `lxp_unit`

## Requirements
- R1: An instruction is recognised only when bit 31=1, bits 29:23=0010000, bit 22=1, bit 21=1 and bit 15=1. Any other word accepted while idle gives a one-cycle `fault_undef` and no request. Bits 20:16 are ignored.
- R2: Bit 30 selects the element size: 0 gives 32-bit elements and `mem_req_bytes`=8, 1 gives 64-bit elements and `mem_req_bytes`=16. `mem_req_atomic` is 1 exactly when the elements are 32-bit.
- R3: `mem_req_acquire` is 1 only when neither the first destination (bits 4:0) nor the second destination (bits 14:10) equals 31.
- R4: `mem_req_tagchk` is 1 only when the base field (bits 9:5) is not 31.
- R5: `rd_idx` always shows bits 9:5 of `in_instr`. The request address is `sp_value` when the base field is 31, and `rd_data` otherwise.
- R6: When the base field is 31 and `sp_value[3:0]` is not zero, `fault_align` pulses for one cycle. No request is issued and the monitor is not armed.
- R7: An accepted load drives `mem_req_valid` high for exactly the one cycle after acceptance. From that same cycle, before any response, the monitor holds the request address and byte count. While a load waits for its response, `busy` is 1 and `in_valid` is ignored.
- R8: The cycle after `mem_rsp_valid`, the destinations are written. In little-endian mode the first destination gets the lower element of `mem_rsp_data` and the second destination gets the upper element. In big-endian mode (`big_endian`=1) the two are swapped.
- R9: A write whose register index is 31 is dropped (its enable stays 0). For 32-bit elements, bits 63:32 of the written data are zero.
- R10: When the two destination fields are equal, `overlap_policy` decides what happens:
  - 0: the load runs and only the first destination is written, with FILL_VALUE (default 64'hDEAD_BEEF_0BAD_F00D; lower half only for 32-bit elements).
  - 1: `fault_undef` is raised and no request is issued.
  - 2 or 3: nothing happens.
- R11: `sx_ok` pulses the cycle after `sx_valid` only when the monitor is armed and both `sx_addr` and `sx_bytes` match the armed values. Every check disarms the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_instr | input | 32 | Instruction word |
| big_endian | input | 1 | Data endianness for the element order |
| overlap_policy | input | 2 | Handling of equal destinations |
| busy | output | 1 | Waiting for memory response |
| rd_idx | output | 5 | Base register read index |
| rd_data | input | 64 | Base register value |
| sp_value | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 64 | Request address |
| mem_req_bytes | output | 5 | Request byte count |
| mem_req_acquire | output | 1 | Acquire ordering sideband |
| mem_req_tagchk | output | 1 | Tag-check sideband |
| mem_req_atomic | output | 1 | Whole pair as one atomic access |
| mem_rsp_valid | input | 1 | Memory data returned |
| mem_rsp_data | input | 128 | Returned pair data |
| wb0_en | output | 1 | First destination write enable |
| wb0_idx | output | 5 | First destination index |
| wb0_data | output | 64 | First destination data |
| wb1_en | output | 1 | Second destination write enable |
| wb1_idx | output | 5 | Second destination index |
| wb1_data | output | 64 | Second destination data |
| fault_align | output | 1 | Stack pointer alignment fault |
| fault_undef | output | 1 | Undefined instruction fault |
| sx_valid | input | 1 | Store-exclusive check request |
| sx_addr | input | 64 | Store address |
| sx_bytes | input | 5 | Store byte count |
| sx_ok | output | 1 | Store-exclusive would succeed |

## Verification
The hardest state to reach is a monitor that is armed and then checked against a store that differs in only one respect: the byte count, or the address, or the fact that the arming load faulted. Reaching it takes a full load round trip first, followed by a check.

The stimulus covers these cases in two ways:
- Every random load is followed by a matching check, which must succeed, and then a repeat check, which must fail because the first check disarmed the monitor.
- Directed sequences arm the monitor and probe it with the wrong size, and also probe it after a misaligned stack pointer suppressed the arming.

// File: rtl/lxp_pkg.sv
package lxp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lxp_state_e;

    typedef enum logic [1:0] {
        OVL_UNKNOWN = 2'd0,
        OVL_UNDEF   = 2'd1,
        OVL_NOP     = 2'd2,
        OVL_NOP_ALT = 2'd3
    } lxp_ovl_e;

    typedef struct packed {
        logic       match;
        logic       is64;
        logic [4:0] rt;
        logic [4:0] rt2;
        logic [4:0] rn;
        logic       acquire;
        logic       tagchk;
        logic       overlap;
        logic       base_is_sp;
    } lxp_dec_t;

endpackage

// File: rtl/lxp_decode.sv
module lxp_decode
    import lxp_pkg::*;
(
    input  logic [31:0] instr,
    output lxp_dec_t    dec
);
    localparam logic [4:0] ZR = 5'd31;

    always_comb begin
        dec.match      = instr[31] && (instr[29:23] == 7'b0010000) &&
                         instr[22] && instr[21] && instr[15];
        dec.is64       = instr[30];
        dec.rt         = instr[4:0];
        dec.rt2        = instr[14:10];
        dec.rn         = instr[9:5];
        dec.acquire    = (instr[4:0] != ZR) && (instr[14:10] != ZR);
        dec.tagchk     = (instr[9:5] != ZR);
        dec.base_is_sp = (instr[9:5] == ZR);
        dec.overlap    = (instr[4:0] == instr[14:10]);
    end
endmodule

// File: rtl/lxp_split.sv
module lxp_split #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] data,
    input  logic              is64,
    input  logic              be,
    output logic [XLEN-1:0]   first,
    output logic [XLEN-1:0]   second
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] lo_el;
    logic [XLEN-1:0] hi_el;

    always_comb begin
        if (is64) begin
            lo_el = data[XLEN-1:0];
            hi_el = data[2*XLEN-1:XLEN];
        end else begin
            lo_el = {{HALF{1'b0}}, data[HALF-1:0]};
            hi_el = {{HALF{1'b0}}, data[XLEN-1:HALF]};
        end
        first  = be ? hi_el : lo_el;
        second = be ? lo_el : hi_el;
    end
endmodule

// File: rtl/lxp_unit.sv
module lxp_unit
    import lxp_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              IDX_W      = 5,
    parameter int              SP_ALIGN   = 4,
    parameter logic [XLEN-1:0] FILL_VALUE = 64'hDEAD_BEEF_0BAD_F00D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         in_instr,
    input  logic                big_endian,
    input  logic [1:0]          overlap_policy,
    output logic                busy,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [XLEN-1:0]     rd_data,
    input  logic [XLEN-1:0]     sp_value,
    output logic                mem_req_valid,
    output logic [XLEN-1:0]     mem_req_addr,
    output logic [4:0]          mem_req_bytes,
    output logic                mem_req_acquire,
    output logic                mem_req_tagchk,
    output logic                mem_req_atomic,
    input  logic                mem_rsp_valid,
    input  logic [2*XLEN-1:0]   mem_rsp_data,
    output logic                wb0_en,
    output logic [IDX_W-1:0]    wb0_idx,
    output logic [XLEN-1:0]     wb0_data,
    output logic                wb1_en,
    output logic [IDX_W-1:0]    wb1_idx,
    output logic [XLEN-1:0]     wb1_data,
    output logic                fault_align,
    output logic                fault_undef,
    input  logic                sx_valid,
    input  logic [XLEN-1:0]     sx_addr,
    input  logic [4:0]          sx_bytes,
    output logic                sx_ok
);
    localparam int             HALF   = XLEN / 2;
    localparam logic [4:0]     PAIR32 = 5'd8;
    localparam logic [4:0]     PAIR64 = 5'd16;
    localparam logic [IDX_W-1:0] ZR   = '1;

    typedef struct packed {
        lxp_state_e       st;
        logic             req_v;
        logic [XLEN-1:0]  req_addr;
        logic [4:0]       req_bytes;
        logic             req_acq;
        logic             req_tag;
        logic             req_atom;
        logic             is64;
        logic             be;
        logic             ovl_unknown;
        logic [IDX_W-1:0] rt;
        logic [IDX_W-1:0] rt2;
        logic             wb0_en;
        logic [IDX_W-1:0] wb0_idx;
        logic [XLEN-1:0]  wb0_data;
        logic             wb1_en;
        logic [IDX_W-1:0] wb1_idx;
        logic [XLEN-1:0]  wb1_data;
        logic             f_align;
        logic             f_undef;
        logic             mon_armed;
        logic [XLEN-1:0]  mon_addr;
        logic [4:0]       mon_bytes;
        logic             sx_ok;
    } unit_state_t;

    unit_state_t q, d;
    lxp_dec_t    dec;
    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] el_first;
    logic [XLEN-1:0] el_second;
    logic [XLEN-1:0] fill_sized;
    logic            sp_misaligned;

    lxp_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    lxp_split #(.XLEN(XLEN)) u_split (
        .data   (mem_rsp_data),
        .is64   (q.is64),
        .be     (q.be),
        .first  (el_first),
        .second (el_second)
    );

    assign rd_idx        = in_instr[9:5];
    assign base_addr     = dec.base_is_sp ? sp_value : rd_data;
    assign sp_misaligned = dec.base_is_sp && (sp_value[SP_ALIGN-1:0] != '0);
    assign fill_sized    = q.is64 ? FILL_VALUE : {{HALF{1'b0}}, FILL_VALUE[HALF-1:0]};

    always_comb begin
        d         = q;
        d.req_v   = 1'b0;
        d.wb0_en  = 1'b0;
        d.wb1_en  = 1'b0;
        d.f_align = 1'b0;
        d.f_undef = 1'b0;
        d.sx_ok   = 1'b0;

        if (sx_valid) begin
            d.sx_ok     = q.mon_armed && (sx_addr == q.mon_addr) &&
                          (sx_bytes == q.mon_bytes);
            d.mon_armed = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!dec.match) begin
                        d.f_undef = 1'b1;
                    end else if (dec.overlap &&
                                 lxp_ovl_e'(overlap_policy) == OVL_UNDEF) begin
                        d.f_undef = 1'b1;
                    end else if (dec.overlap &&
                                 lxp_ovl_e'(overlap_policy) != OVL_UNKNOWN) begin
                        d.f_undef = 1'b0;
                    end else if (sp_misaligned) begin
                        d.f_align = 1'b1;
                    end else begin
                        d.st          = ST_WAIT;
                        d.req_v       = 1'b1;
                        d.req_addr    = base_addr;
                        d.req_bytes   = dec.is64 ? PAIR64 : PAIR32;
                        d.req_acq     = dec.acquire;
                        d.req_tag     = dec.tagchk;
                        d.req_atom    = !dec.is64;
                        d.is64        = dec.is64;
                        d.be          = big_endian;
                        d.ovl_unknown = dec.overlap;
                        d.rt          = dec.rt;
                        d.rt2         = dec.rt2;
                        d.mon_armed   = 1'b1;
                        d.mon_addr    = base_addr;
                        d.mon_bytes   = dec.is64 ? PAIR64 : PAIR32;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st      = ST_IDLE;
                    d.wb0_idx = q.rt;
                    d.wb1_idx = q.rt2;
                    d.wb0_en  = (q.rt != ZR);
                    if (q.ovl_unknown) begin
                        d.wb0_data = fill_sized;
                        d.wb1_en   = 1'b0;
                    end else begin
                        d.wb0_data = el_first;
                        d.wb1_data = el_second;
                        d.wb1_en   = (q.rt2 != ZR);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy            = (q.st == ST_WAIT);
    assign mem_req_valid   = q.req_v;
    assign mem_req_addr    = q.req_addr;
    assign mem_req_bytes   = q.req_bytes;
    assign mem_req_acquire = q.req_acq;
    assign mem_req_tagchk  = q.req_tag;
    assign mem_req_atomic  = q.req_atom;
    assign wb0_en          = q.wb0_en;
    assign wb0_idx         = q.wb0_idx;
    assign wb0_data        = q.wb0_data;
    assign wb1_en          = q.wb1_en;
    assign wb1_idx         = q.wb1_idx;
    assign wb1_data        = q.wb1_data;
    assign fault_align     = q.f_align;
    assign fault_undef     = q.f_undef;
    assign sx_ok           = q.sx_ok;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R7
    AST_NO_REQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_align || fault_undef) |-> !mem_req_valid); // R6
    AST_ARMED_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (q.mon_armed && q.mon_addr == mem_req_addr &&
                           q.mon_bytes == mem_req_bytes)); // R7
    AST_PAIR_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_atomic ? mem_req_bytes == PAIR32
                                          : mem_req_bytes == PAIR64)); // R2
    AST_ZERO_REG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en |-> wb0_idx != ZR) and (wb1_en |-> wb1_idx != ZR)); // R9
    AST_SX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (sx_valid && !(q.st == ST_IDLE && in_valid)) |=> !q.mon_armed); // R11
    AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en || wb1_en) |-> $past(mem_rsp_valid && busy)); // R8
endmodule

// File: tb/sim_lxp_unit.sv
module sim_lxp_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] FILL = 64'hDEAD_BEEF_0BAD_F00D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic big_endian = 1'b0;
    logic [1:0] overlap_policy = 2'd0;
    logic busy;
    logic [4:0] rd_idx;
    logic [63:0] rd_data;
    logic [63:0] sp_value = '0;
    logic mem_req_valid, mem_req_acquire, mem_req_tagchk, mem_req_atomic;
    logic [63:0] mem_req_addr;
    logic [4:0] mem_req_bytes;
    logic mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic wb0_en, wb1_en;
    logic [4:0] wb0_idx, wb1_idx;
    logic [63:0] wb0_data, wb1_data;
    logic fault_align, fault_undef;
    logic sx_valid = 1'b0;
    logic [63:0] sx_addr = '0;
    logic [4:0] sx_bytes = '0;
    logic sx_ok;

    logic [63:0] gpr [0:31];
    int n_checks = 0;
    int n_fail = 0;
    int seed = 7;

    assign rd_data = gpr[rd_idx];

    always #(CLK_PERIOD/2) clk = ~clk;

    lxp_unit u0 (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic sz, input logic [4:0] rt2,
                                        input logic [4:0] rn, input logic [4:0] rt,
                                        input logic [4:0] sbo);
        return {1'b1, sz, 7'b0010000, 1'b1, 1'b1, sbo, 1'b1, rt2, rn, rt};
    endfunction

    function automatic logic [63:0] elem(input logic [127:0] dt, input logic sz, input logic hi);
        if (sz) return hi ? dt[127:64] : dt[63:0];
        return hi ? {32'd0, dt[63:32]} : {32'd0, dt[31:0]};
    endfunction

    task automatic issue(input logic [31:0] ins);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic respond(input logic [127:0] dt);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = dt;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    task automatic sx_probe(input logic [63:0] a, input logic [4:0] b, input logic exp, input string tag);
        sx_valid = 1'b1;
        sx_addr = a;
        sx_bytes = b;
        @(negedge clk);
        sx_valid = 1'b0;
        chk(tag, {63'd0, sx_ok}, {63'd0, exp});
    endtask

    task automatic full_load(input logic sz, input logic [4:0] rt, input logic [4:0] rt2,
                             input logic [4:0] rn, input logic be, input logic [4:0] sbo,
                             input logic [127:0] dt);
        logic [63:0] ea;
        ea = (rn == 5'd31) ? sp_value : gpr[rn];
        big_endian = be;
        issue(enc(sz, rt2, rn, rt, sbo));
        chk("R1 req_valid", {63'd0, mem_req_valid}, 64'd1);
        chk("R5 addr", mem_req_addr, ea);
        chk("R2 bytes", {59'd0, mem_req_bytes}, sz ? 64'd16 : 64'd8);
        chk("R2 atomic", {63'd0, mem_req_atomic}, {63'd0, !sz});
        chk("R3 acquire", {63'd0, mem_req_acquire}, {63'd0, (rt != 31) && (rt2 != 31)});
        chk("R4 tagchk", {63'd0, mem_req_tagchk}, {63'd0, rn != 31});
        chk("R7 busy", {63'd0, busy}, 64'd1);
        respond(dt);
        chk("R9 wb0_en", {63'd0, wb0_en}, {63'd0, rt != 31});
        chk("R9 wb1_en", {63'd0, wb1_en}, {63'd0, rt2 != 31});
        if (rt != 31) begin
            chk("R8 wb0_idx", {59'd0, wb0_idx}, {59'd0, rt});
            chk("R8 wb0_data", wb0_data, elem(dt, sz, be));
        end
        if (rt2 != 31) begin
            chk("R8 wb1_idx", {59'd0, wb1_idx}, {59'd0, rt2});
            chk("R8 wb1_data", wb1_data, elem(dt, sz, !be));
        end
        chk("R7 idle", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(seed));
        for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset busy", {63'd0, busy}, 64'd0);
        chk("R7 reset req", {63'd0, mem_req_valid}, 64'd0);
        chk("R6 reset faults", {62'd0, fault_align, fault_undef}, 64'd0);
        chk("R11 reset sx", {63'd0, sx_ok}, 64'd0);

        // random loads, each followed by matching and repeat exclusive checks
        for (int i = 0; i < 60; i++) begin
            logic sz;
            logic [4:0] rt, rt2, rn;
            logic [63:0] ea;
            sz = 1'($urandom);
            rt = 5'($urandom);
            rt2 = 5'($urandom);
            if (rt2 == rt) rt2 = rt + 5'd1;
            rn = (i % 5 == 0) ? 5'd31 : 5'($urandom);
            sp_value = {$urandom, $urandom} & ~64'hF;
            ea = (rn == 5'd31) ? sp_value : gpr[rn];
            full_load(sz, rt, rt2, rn, 1'($urandom), 5'($urandom),
                      {$urandom, $urandom, $urandom, $urandom});
            sx_probe(ea, sz ? 5'd16 : 5'd8, 1'b1, "R11 match");
            sx_probe(ea, sz ? 5'd16 : 5'd8, 1'b0, "R11 cleared");
        end

        // zero-register destinations
        full_load(1'b1, 5'd31, 5'd4, 5'd2, 1'b0, 5'h1F, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        full_load(1'b0, 5'd3, 5'd31, 5'd31, 1'b1, 5'h00, 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0123);

        // size mismatch on store-exclusive
        full_load(1'b0, 5'd1, 5'd2, 5'd5, 1'b0, 5'h1F, 128'h0);
        sx_probe(gpr[5], 5'd16, 1'b0, "R11 size mismatch");

        // misaligned stack pointer
        sp_value = 64'h1000_0008;
        issue(enc(1'b1, 5'd1, 5'd31, 5'd2, 5'h1F));
        chk("R6 align fault", {63'd0, fault_align}, 64'd1);
        chk("R6 no request", {63'd0, mem_req_valid}, 64'd0);
        chk("R6 not busy", {63'd0, busy}, 64'd0);
        sx_probe(64'h1000_0008, 5'd16, 1'b0, "R6 monitor not armed");

        // bad encoding: load bit cleared
        issue(enc(1'b1, 5'd1, 5'd3, 5'd2, 5'h1F) & ~32'h0040_0000);
        chk("R1 undef", {63'd0, fault_undef}, 64'd1);
        chk("R1 no request", {63'd0, mem_req_valid}, 64'd0);

        // overlap: undef policy
        overlap_policy = 2'd1;
        issue(enc(1'b1, 5'd6, 5'd3, 5'd6, 5'h1F));
        chk("R10 undef", {63'd0, fault_undef}, 64'd1);
        chk("R10 undef no req", {63'd0, mem_req_valid}, 64'd0);

        // overlap: no-op policy
        overlap_policy = 2'd2;
        issue(enc(1'b1, 5'd6, 5'd3, 5'd6, 5'h1F));
        chk("R10 nop quiet", {61'd0, mem_req_valid, fault_undef, fault_align}, 64'd0);
        chk("R10 nop idle", {63'd0, busy}, 64'd0);

        // overlap: unknown-value policy, 32-bit elements
        overlap_policy = 2'd0;
        issue(enc(1'b0, 5'd7, 5'd3, 5'd7, 5'h1F));
        chk("R10 unknown req", {63'd0, mem_req_valid}, 64'd1);
        respond(128'h5);
        chk("R10 unknown wb0_en", {63'd0, wb0_en}, 64'd1);
        chk("R10 unknown fill", wb0_data, {32'd0, FILL[31:0]});
        chk("R10 unknown wb1_en", {63'd0, wb1_en}, 64'd0);

        // input ignored while waiting
        issue(enc(1'b1, 5'd1, 5'd3, 5'd2, 5'h1F));
        issue(enc(1'b0, 5'd8, 5'd4, 5'd9, 5'h1F));
        chk("R7 ignored while busy", {63'd0, mem_req_valid}, 64'd0);
        respond(128'h0);
        chk("R7 first completes", {59'd0, wb0_idx}, 64'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule